// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a 32-bit processor that finishes every instruction in one clock cycle. It handles word load, word store, add, subtract, AND, OR, signed set-on-less-than, branch-if-equal and jump. Each cycle it fetches a word from an internal instruction array at the program counter and decodes it. It reads two registers and runs the ALU. Then it either writes a register, writes the internal data array, or redirects the program counter.

Both memories are word-addressed arrays inside the block. While reset is held, a simple load port fills either array, so a program and its data are in place before execution starts. The store side of the data memory is also driven out on output ports, which lets surrounding logic observe every memory write the program makes.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and the register file is cleared. Execution starts at address 0 on the first edge after `rst` falls.
- R2: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0], immediate [15:0] and jump target [25:0]. A non-control instruction advances the PC by 4.
- R3: Opcode 0 is register format, with the result written to rd. funct 6'b100000 adds, 6'b100010 subtracts (rs minus rt), 6'b100100 ANDs and 6'b100101 ORs.
- R4: Register-format funct 6'b101010 writes 1 to rd when rs is less than rt as signed values, and 0 otherwise.
- R5: Opcode 35 loads the data word at rs plus the sign-extended immediate into rt. Opcode 43 stores rt at that address without writing any register. `st_en` is high during the store cycle, with `st_addr` and `st_data` carrying the byte address and the data.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4.
- R7: Opcode 2 sets the PC to the upper 4 bits of the current PC, followed by the 26-bit target, followed by two zero bits.
- R8: Register 0 always reads as 0; writes that name it are discarded.
- R9: Any other opcode changes no register and no memory; it only advances the PC by 4.
- R10: With `ld_en` high while `rst` is high, `ld_data` is written at word index `ld_addr` into the instruction array (`ld_imem`=1) or the data array (`ld_imem`=0). While `rst` is low, `ld_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Preload write strobe, honoured only in reset |
| ld_imem | input | 1 | Preload target: 1 instruction array, 0 data array |
| ld_addr | input | ADDR_W | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| st_en | output | 1 | Data store taking place this cycle |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word being stored |

## Verification
The bench builds the core with ADDR_W=6, which gives 64-word instruction and data arrays. That is room enough for a 29-word program placed at the bottom of the instruction array, data at low word indices, and a forward jump to byte 100. The program covers every funct code and a signed comparison in both directions. It also includes a write to register 0, a branch that is taken and one that is not, a negative store offset, an unsupported opcode and a backward self-branch that parks the core. With the small arrays, the word index is taken from PC bits [7:2], so jump and branch targets fall within the array. A late preload attempt outside reset is expected to leave the parked program untouched.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic              ld_imem,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [31:0]       ld_data,
  output logic [31:0]       pc_o,
  output logic              st_en,
  output logic [31:0]       st_addr,
  output logic [31:0]       st_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [3:0] ALU_AND = 4'b0000, ALU_OR = 4'b0001, ALU_ADD = 4'b0010,
                         ALU_SUB = 4'b0110, ALU_SLT = 4'b0111, ALU_NOR = 4'b1100,
                         ALU_BAD = 4'b1111;

  logic [31:0] imem [DEPTH];
  logic [31:0] dmem [DEPTH];
  logic [31:0] rf   [32];
  logic [31:0] pc, instr;

  assign instr = imem[pc[ADDR_W+1:2]];

  wire [5:0]  op    = instr[31:26];
  wire [4:0]  rs    = instr[25:21];
  wire [4:0]  rt    = instr[20:16];
  wire [4:0]  rd    = instr[15:11];
  wire [5:0]  funct = instr[5:0];
  wire [31:0] simm  = {{16{instr[15]}}, instr[15:0]};
  wire        unused_shamt = &{1'b0, instr[10:6]};

  wire is_r   = op == 6'd0;
  wire is_lw  = op == 6'd35;
  wire is_sw  = op == 6'd43;
  wire is_beq = op == 6'd4;
  wire is_j   = op == 6'd2;

  wire [1:0] alu_op = is_r ? 2'b10 : (is_beq ? 2'b01 : 2'b00);
  logic [3:0] alu_ctl;
  always_comb begin
    case (alu_op)
      2'b00: alu_ctl = ALU_ADD;
      2'b01: alu_ctl = ALU_SUB;
      default:
        case (funct)
          6'b100000: alu_ctl = ALU_ADD;
          6'b100010: alu_ctl = ALU_SUB;
          6'b100100: alu_ctl = ALU_AND;
          6'b100101: alu_ctl = ALU_OR;
          6'b101010: alu_ctl = ALU_SLT;
          default:   alu_ctl = ALU_BAD;
        endcase
    endcase
  end

  wire [31:0] a = (rs == 5'd0) ? 32'd0 : rf[rs];
  wire [31:0] rt_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  wire [31:0] b = (is_lw || is_sw) ? simm : rt_val;

  logic [31:0] alu_y;
  always_comb begin
    case (alu_ctl)
      ALU_AND: alu_y = a & b;
      ALU_OR:  alu_y = a | b;
      ALU_ADD: alu_y = a + b;
      ALU_SUB: alu_y = a - b;
      ALU_SLT: alu_y = {31'd0, $signed(a) < $signed(b)};
      ALU_NOR: alu_y = ~(a | b);
      default: alu_y = 32'd0;
    endcase
  end
  wire zero = alu_y == 32'd0;

  wire        rf_we = (is_r && alu_ctl != ALU_BAD) || is_lw;
  wire [4:0]  wa    = is_r ? rd : rt;
  wire [31:0] ld_w  = dmem[alu_y[ADDR_W+1:2]];
  wire [31:0] wd    = is_lw ? ld_w : alu_y;

  wire [31:0] pc4     = pc + 32'd4;
  wire [31:0] br_tgt  = pc4 + {simm[29:0], 2'b00};
  wire [31:0] next_pc = is_j ? {pc[31:28], instr[25:0], 2'b00}
                      : (is_beq && zero) ? br_tgt : pc4;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (rf_we && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && ld_imem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (ld_en && !ld_imem) dmem[ld_addr] <= ld_data;
    end else if (is_sw) begin
      dmem[alu_y[ADDR_W+1:2]] <= rt_val;
    end
  end

  assign pc_o    = pc;
  assign st_en   = !rst && is_sw;
  assign st_addr = alu_y;
  assign st_data = rt_val;

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (!is_j && !is_beq) |=> pc == $past(pc) + 32'd4);

  assert_store_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !rf_we);

  assert_beq_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (is_beq && a == rt_val) |=> pc == $past(pc) + 32'd4 + {$past(simm[29:0]), 2'b00});

  assert_jump_R7: assert property (@(posedge clk) disable iff (rst)
    is_j |=> pc[27:0] == {$past(instr[25:0]), 2'b00});

  assert_r0_held_R8: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0);
endmodule

// File: tb/test_sc_core.sv
module test_sc_core;
  localparam int ADDR_W = 6;
  logic clk = 0, rst = 1, ld_en = 0, ld_imem = 0;
  logic [ADDR_W-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, st_addr, st_data;
  logic st_en;
  int errors = 0, checks = 0;
  logic [63:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  sc_core #(.ADDR_W(ADDR_W)) i_sc_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .st_en(st_en), .st_addr(st_addr), .st_data(st_data));

  function automatic logic [31:0] rfmt(int s, int t, int d, logic [5:0] f);
    return {6'd0, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] ifmt(logic [5:0] o, int s, int t, logic [15:0] im);
    return {o, 5'(s), 5'(t), im};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(logic im, int idx, logic [31:0] w);
    @(negedge clk);
    ld_en = 1; ld_imem = im; ld_addr = ADDR_W'(idx); ld_data = w;
  endtask

  task automatic expect_store(int addr, logic [31:0] d, string req);
    exp_q.push_back({32'(addr), d});
    tag_q.push_back(req);
  endtask

  // monitor: compares every store against the scoreboard
  always @(negedge clk) begin
    if (!rst && st_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10/R9: unexpected store actual %h:%h expected none", st_addr, st_data);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " addr"}, st_addr, e[63:32]);
        check({t, " data"}, st_data, e[31:0]);
      end
    end
  end

  initial begin
    int n;
    logic [31:0] prog [29];
    prog[0]  = ifmt(6'd35, 0, 1, 16'd0);
    prog[1]  = ifmt(6'd35, 0, 2, 16'd4);
    prog[2]  = rfmt(1, 2, 3, 6'b100000);
    prog[3]  = ifmt(6'd43, 0, 3, 16'd16);
    prog[4]  = rfmt(1, 2, 4, 6'b100010);
    prog[5]  = ifmt(6'd43, 0, 4, 16'd20);
    prog[6]  = rfmt(1, 2, 5, 6'b100100);
    prog[7]  = ifmt(6'd43, 0, 5, 16'd24);
    prog[8]  = rfmt(1, 2, 6, 6'b100101);
    prog[9]  = ifmt(6'd43, 0, 6, 16'd28);
    prog[10] = rfmt(2, 1, 7, 6'b101010);
    prog[11] = ifmt(6'd43, 0, 7, 16'd32);
    prog[12] = rfmt(1, 2, 8, 6'b101010);
    prog[13] = ifmt(6'd43, 0, 8, 16'd36);
    prog[14] = rfmt(1, 1, 0, 6'b100000);
    prog[15] = ifmt(6'd43, 0, 0, 16'd40);
    prog[16] = ifmt(6'd4, 1, 2, 16'd5);
    prog[17] = ifmt(6'd43, 0, 1, 16'd44);
    prog[18] = ifmt(6'd4, 1, 1, 16'd2);
    prog[19] = ifmt(6'd43, 0, 1, 16'd48);
    prog[20] = ifmt(6'd43, 0, 1, 16'd52);
    prog[21] = ifmt(6'd43, 4, 2, 16'hFFFC);
    prog[22] = {6'd2, 26'd25};
    prog[23] = ifmt(6'd43, 0, 1, 16'd56);
    prog[24] = ifmt(6'd43, 0, 1, 16'd60);
    prog[25] = 32'hFC21_0000;
    prog[26] = ifmt(6'd35, 0, 9, 16'd16);
    prog[27] = ifmt(6'd43, 0, 9, 16'd64);
    prog[28] = ifmt(6'd4, 0, 0, 16'hFFFF);

    for (int i = 0; i < 29; i++) load(1'b1, i, prog[i]);
    load(1'b0, 0, 32'd7);
    load(1'b0, 1, 32'hFFFF_FFFB);
    @(negedge clk); ld_en = 0;
    check("R1 pc in reset", pc_o, 32'd0);

    expect_store(16, 32'd2, "R3 add/R10 preload");
    expect_store(20, 32'd12, "R3 sub");
    expect_store(24, 32'd3, "R3 and");
    expect_store(28, 32'hFFFF_FFFF, "R3 or");
    expect_store(32, 32'd1, "R4 slt true");
    expect_store(36, 32'd0, "R4 slt false");
    expect_store(40, 32'd0, "R8 r0");
    expect_store(44, 32'd7, "R6 not taken");
    expect_store(8, 32'hFFFF_FFFB, "R5 neg offset/R6 taken");
    expect_store(64, 32'd2, "R7 jump/R9 noop/R5 load");

    rst = 0;
    @(negedge clk);
    check("R2 pc after first instr", pc_o, 32'd4);
    repeat (40) @(negedge clk);
    check("R6 parked pc", pc_o, 32'd112);
    check("R5 all stores seen", 32'(exp_q.size()), 32'd0);

    ld_en = 1; ld_imem = 1; ld_addr = ADDR_W'(28); ld_data = ifmt(6'd43, 0, 1, 16'd0);
    @(negedge clk); ld_en = 0;
    repeat (5) @(negedge clk);
    check("R10 load ignored, pc", pc_o, 32'd112);
    check("R10 load ignored, no store", {31'd0, st_en}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule